// File: doc/BRIEF.md
# Packet Command Decoder with Register File

This block takes 14-bit command words from an upstream sender over a four-phase request/acknowledge channel. It sorts each word into one of three kinds: a configuration register write, a register read, or a spike event. The configuration values live in a small register file of 8-bit registers. A read returns a packed response word on a 14-bit output channel that uses the same handshake. A spike word is passed to the output unchanged. A write changes state and produces no output word.

The handshake is modelled in a clocked, synchronous form, with separate request and acknowledge signals on each side. Only one command is in flight at any time. While any output word is still waiting for the receiver, the next input word is not acknowledged. When the loopback enable is high as a word is accepted, that word is first echoed on the output exactly as it arrived, and its normal response (if it has one) follows. Bit 5 of register 0 drives a debug-enable output.

Top module: `pkt_cmd_unit`

## Requirements
- R1: After reset, inAck and outReq are low and outData is 0. Register 0 holds 255 and every other register holds 0, so debugEn is 1.
- R2: Bit 13 of an input word selects the kind. 1 means a register command and 0 means a spike event.
- R3: A register command with bit 12 = 1 is a write. Bits 11:4 are written into the register addressed by bits 3:0. The write is acknowledged on the input and emits no output word.
- R4: A register command with bit 12 = 0 is a read. It emits one word {2'b00, value[7:0], addr[3:0]}, and the data field of the command is ignored. Examples: register 1 holding 17 gives 273, and register 5 holding 255 gives 4085.
- R5: A spike word (bit 13 clear, such as 7 for synapse [1,3]) is emitted on the output with all 14 bits unchanged.
- R6: If loopbackEn is high when a word is accepted, that word is emitted unchanged first. Any response follows only after the echo has been acknowledged.
- R7: On the input side, inAck rises after inReq rises and stays high until inReq falls. On the output side, outData is held stable while outReq is high until outAck rises. outReq then falls, and outData is 0 whenever outReq is low.
- R8: While an output word, or a queued echo and response pair, is still pending, a new inReq is not acknowledged.
- R9: A write to an address at or beyond NREG (8 by default) is acknowledged and discarded. A read of such an address returns a data field of 0.
- R10: A read returns the register value after every earlier write has taken effect.
- R11: debugEn always equals bit 5 of register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inReq | input | 1 | Input channel request |
| inData | input | 14 | Input command word |
| inAck | output | 1 | Input channel acknowledge |
| outReq | output | 1 | Output channel request |
| outData | output | 14 | Output word, 0 when idle |
| outAck | input | 1 | Output channel acknowledge |
| loopbackEn | input | 1 | Echo each accepted word before its response |
| debugEn | output | 1 | Bit 5 of register 0 |

## Verification
The hardest state to reach from the ports is a new request arriving while an echo and its response are both still queued behind a stalled receiver. The bench reaches it by sending a loopback read and leaving outAck low. It then raises inReq with a spike word and watches inAck stay low for many cycles. After that it drains both pending words in order and confirms that the held spike is then accepted and echoed.

// File: rtl/pkt_cmd_pkg.sv
package pkt_cmd_pkg;
  localparam int WORD_W = 14;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_IN_ACK,
    ST_ECHO_SEND,
    ST_ECHO_REL,
    ST_RESP_SEND,
    ST_RESP_REL
  } ctrl_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch the input word and build its response
    logic doWrite;   // commit the register write of the latched command
    logic driveOut;  // present a word on outData
    logic selEcho;   // 1: raw echo word, 0: response word
  } dp_ctl_t;
endpackage

// File: rtl/pkt_cmd_dpath.sv
module pkt_cmd_dpath
  import pkt_cmd_pkg::*;
#(
  parameter int WORD_W = pkt_cmd_pkg::WORD_W,
  parameter int DATA_W = pkt_cmd_pkg::DATA_W,
  parameter int ADDR_W = pkt_cmd_pkg::ADDR_W,
  parameter int NREG   = 8,
  parameter logic [DATA_W-1:0] REG0_RST = '1,
  parameter int DBG_BIT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] inData,
  input  dp_ctl_t           ctl,
  output logic              cmdIsWrite,
  output logic [WORD_W-1:0] outData,
  output logic              debugEn
);
  localparam int KIND_BIT = WORD_W - 1;
  localparam int WR_BIT   = WORD_W - 2;
  localparam int PAD_W    = WORD_W - DATA_W - ADDR_W;

  logic [DATA_W-1:0] regFile [NREG];
  logic [WORD_W-1:0] echoQ, respQ, respNext;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DATA_W-1:0] cmdVal, rdVal;
  logic              cmdIsReg;

  assign cmdIsReg   = inData[KIND_BIT];
  assign cmdIsWrite = cmdIsReg & inData[WR_BIT];
  assign cmdAddr    = inData[ADDR_W-1:0];
  assign cmdVal     = inData[ADDR_W +: DATA_W];

  // register file, one reset value per entry
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL = (i == 0) ? REG0_RST : '0;
    always_ff @(posedge clk) begin
      if (!rstN) regFile[i] <= RST_VAL;
      else if (ctl.doWrite && cmdAddr == ADDR_W'(i)) regFile[i] <= cmdVal;
    end
  end

  always_comb begin
    rdVal = '0;
    for (int i = 0; i < NREG; i++)
      if (cmdAddr == ADDR_W'(i)) rdVal = regFile[i];
  end

  always_comb begin
    if (cmdIsReg) respNext = {{PAD_W{1'b0}}, rdVal, cmdAddr};
    else          respNext = inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      echoQ <= '0;
      respQ <= '0;
    end else if (ctl.capture) begin
      echoQ <= inData;
      respQ <= respNext;
    end
  end

  assign outData = ctl.driveOut ? (ctl.selEcho ? echoQ : respQ) : '0;
  assign debugEn = regFile[0][DBG_BIT];

  // R3: a committed write lands in the register file (checked on register 0)
  a_r3_write_reg0: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.doWrite && cmdAddr == '0) |=> (regFile[0] == $past(cmdVal)));
endmodule

// File: rtl/pkt_cmd_ctrl.sv
module pkt_cmd_ctrl
  import pkt_cmd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inReq,
  input  logic    outAck,
  input  logic    loopbackEn,
  input  logic    cmdIsWrite,
  output logic    inAck,
  output logic    outReq,
  output dp_ctl_t ctl
);
  ctrl_state_e state, stateNext;
  logic pendEcho, pendResp;

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    case (state)
      ST_IDLE: if (inReq) begin
        ctl.capture = 1'b1;
        ctl.doWrite = cmdIsWrite;
        stateNext   = ST_IN_ACK;
      end
      ST_IN_ACK: if (!inReq)
        stateNext = pendEcho ? ST_ECHO_SEND : (pendResp ? ST_RESP_SEND : ST_IDLE);
      ST_ECHO_SEND: begin
        ctl.driveOut = 1'b1;
        ctl.selEcho  = 1'b1;
        if (outAck) stateNext = ST_ECHO_REL;
      end
      ST_ECHO_REL: if (!outAck)
        stateNext = pendResp ? ST_RESP_SEND : ST_IDLE;
      ST_RESP_SEND: begin
        ctl.driveOut = 1'b1;
        if (outAck) stateNext = ST_RESP_REL;
      end
      ST_RESP_REL: if (!outAck) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      pendEcho <= 1'b0;
      pendResp <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.capture) begin
        pendEcho <= loopbackEn;
        pendResp <= !cmdIsWrite;
      end
    end
  end

  assign inAck  = (state == ST_IN_ACK);
  assign outReq = (state == ST_ECHO_SEND) || (state == ST_RESP_SEND);

  // R7: input acknowledge is held while the request stays high
  a_r7_in_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inAck && inReq) |=> inAck);
  // R7: output request only drops after the receiver acknowledged
  a_r7_out_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(outReq) |-> $past(outAck));
  // R8: never acknowledge input while an output word is offered
  a_r8_single_flight: assert property (@(posedge clk) disable iff (!rstN)
    outReq |-> !inAck);
endmodule

// File: rtl/pkt_cmd_unit.sv
module pkt_cmd_unit
  import pkt_cmd_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inReq,
  input  logic [13:0] inData,
  output logic        inAck,
  output logic        outReq,
  output logic [13:0] outData,
  input  logic        outAck,
  input  logic        loopbackEn,
  output logic        debugEn
);
  dp_ctl_t ctl;
  logic    cmdIsWrite;

  pkt_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inReq(inReq), .outAck(outAck),
    .loopbackEn(loopbackEn), .cmdIsWrite(cmdIsWrite),
    .inAck(inAck), .outReq(outReq), .ctl(ctl)
  );

  pkt_cmd_dpath #(.NREG(NREG)) u_dpath (
    .clk(clk), .rstN(rstN), .inData(inData), .ctl(ctl),
    .cmdIsWrite(cmdIsWrite), .outData(outData), .debugEn(debugEn)
  );

  // R7: an offered word is held until acknowledged
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && !outAck) |=> (outReq && $stable(outData)));
  // R7: neutral output while no request
  a_r7_out_neutral: assert property (@(posedge clk) disable iff (!rstN)
    !outReq |-> (outData == '0));
endmodule

// File: tb/sim_pkt_cmd_unit.sv
`timescale 1ns/1ps
module sim_pkt_cmd_unit;
  logic clk = 0, rstN = 0, inReq = 0, outAck = 0, loopbackEn = 0;
  logic [13:0] inData = '0;
  logic inAck, outReq, debugEn;
  logic [13:0] outData;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pkt_cmd_unit u0 (.clk(clk), .rstN(rstN), .inReq(inReq), .inData(inData),
    .inAck(inAck), .outReq(outReq), .outData(outData), .outAck(outAck),
    .loopbackEn(loopbackEn), .debugEn(debugEn));

  // {loop[44], nOut[43:42], cmd[41:28], exp1[27:14], exp2[13:0]}
  localparam int NV = 15;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 2'd2, 14'd8192,  14'd8192,  14'd4080},  // R6 echo then read reg0 = 255
    {1'b1, 2'd1, 14'd12561, 14'd12561, 14'd0},     // R6 echo of write 17 -> reg1
    {1'b0, 2'd0, 14'd16373, 14'd0,     14'd0},     // R3 write 255 -> reg5
    {1'b0, 2'd1, 14'd8193,  14'd273,   14'd0},     // R10 read reg1
    {1'b0, 2'd1, 14'd8197,  14'd4085,  14'd0},     // R10 read reg5
    {1'b0, 2'd1, 14'd7,     14'd7,     14'd0},     // R5 spike [1,3]
    {1'b0, 2'd1, 14'd4,     14'd4,     14'd0},     // R5 spike [0,2]
    {1'b0, 2'd1, 14'd0,     14'd0,     14'd0},     // R5 spike [0,0]
    {1'b1, 2'd2, 14'd5,     14'd5,     14'd5},     // R6 echo of spike
    {1'b0, 2'd0, 14'd12969, 14'd0,     14'd0},     // R9 write 42 -> addr 9
    {1'b0, 2'd1, 14'd8201,  14'd9,     14'd0},     // R9 read addr 9 -> data 0
    {1'b0, 2'd1, 14'd10929, 14'd273,   14'd0},     // R4 data field ignored
    {1'b0, 2'd1, 14'd4095,  14'd4095,  14'd0},     // R5 wide spike code
    {1'b0, 2'd0, 14'd12800, 14'd0,     14'd0},     // R3 write 32 -> reg0
    {1'b0, 2'd1, 14'd8192,  14'd512,   14'd0}      // R10 read reg0 = 32
  };

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sendWord(input logic [13:0] w);
    int n;
    @(negedge clk);
    inData = w; inReq = 1;
    n = 0;
    while (!inAck && n < 60) begin @(negedge clk); n++; end
    chk("R7 input ack rises", 14'(inAck), 14'd1);
    inReq = 0; inData = '0;
    n = 0;
    while (inAck && n < 60) begin @(negedge clk); n++; end
    chk("R7 input ack falls", 14'(inAck), 14'd0);
  endtask

  task automatic expectOut(input string tag, input logic [13:0] exp);
    int n;
    n = 0;
    while (!outReq && n < 60) begin @(negedge clk); n++; end
    chk(tag, outData, exp);
    repeat (2) @(negedge clk);
    chk("R7 held until ack", outData, exp);
    outAck = 1;
    n = 0;
    while (outReq && n < 60) begin @(negedge clk); n++; end
    chk("R7 neutral after ack", outData, 14'd0);
    outAck = 0;
    @(negedge clk);
  endtask

  task automatic expectSilent(input string tag);
    repeat (8) @(negedge clk);
    chk(tag, 14'(outReq), 14'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R7 actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 inAck", 14'(inAck), 14'd0);
    chk("R1 outReq", 14'(outReq), 14'd0);
    chk("R1 outData", outData, 14'd0);
    chk("R1 R11 debugEn", 14'(debugEn), 14'd1);

    for (int i = 0; i < NV; i++) begin
      logic [13:0] cmd;
      string tag;
      cmd = VEC[i][41:28];
      tag = cmd[13] ? (cmd[12] ? "R2/R3" : "R2/R4") : "R2/R5";
      loopbackEn = VEC[i][44];
      sendWord(cmd);
      if (VEC[i][43:42] == 2'd0) expectSilent({tag, " no output"});
      if (VEC[i][43:42] >= 2'd1)
        expectOut(VEC[i][44] ? "R6 echo first" : tag, VEC[i][27:14]);
      if (VEC[i][43:42] == 2'd2) expectOut({tag, " R6 after echo"}, VEC[i][13:0]);
      loopbackEn = 0;
    end
    chk("R11 debugEn after reg0=32", 14'(debugEn), 14'd1);

    // R11: clear reg0 bit 5
    sendWord(14'd12288);
    expectSilent("R3 write reg0 silent");
    chk("R11 debugEn after reg0=0", 14'(debugEn), 14'd0);

    // R10: write then immediate read of reg2
    sendWord(14'h3000 | (14'd99 << 4) | 14'd2);
    sendWord(14'h2000 | 14'd2);
    expectOut("R10 read after write", (14'd99 << 4) | 14'd2);

    // R9: the out-of-range write did not alias onto reg1
    sendWord(14'h2001);
    expectOut("R9 no alias reg1", 14'd273);

    // R8: hold a new request while echo and response are pending
    loopbackEn = 1;
    sendWord(14'h2001);
    loopbackEn = 0;
    @(negedge clk);
    inData = 14'd3; inReq = 1;
    repeat (12) @(negedge clk);
    chk("R8 no ack while busy", 14'(inAck), 14'd0);
    chk("R8 echo still offered", outData, 14'h2001);
    expectOut("R8 R6 echo", 14'h2001);
    chk("R8 no ack before response", 14'(inAck), 14'd0);
    expectOut("R8 response", 14'd273);
    repeat (3) @(negedge clk);
    chk("R8 held word accepted", 14'(inAck), 14'd1);
    inReq = 0; inData = '0;
    expectOut("R8 R5 held spike", 14'd3);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule